// File: doc/BRIEF.md
# Flash Command Decoder with Erase Suspend

This block sits in front of a small behavioural NOR-style flash array and turns single-byte command writes into array operations. A write strobe carries an address and a command or data byte. A small write state machine runs block erase and single-byte program operations, and each one lasts a parameterised number of clock cycles. A read strobe latches either an array byte or the status byte onto the read data output, depending on the current read mode. A ready pin and an eight-bit status word report progress and failures.

An erase that is running can be suspended partway through. While it is suspended, the host may read the array and may program a byte in any block other than the suspended one. The host may also query, configure, read or clear status, and resume the erase. A resume written while such a program is still in flight is held until that program finishes. The erase then continues from the point where it stopped. Erase and program start only while the program-enable voltage flag is high. That flag is checked again when an erase resumes.

The address is split into a block index in its upper bits and a byte offset in its lower bits. `BLOCK_BYTES` and `NUM_BLOCKS` must both be powers of two, and `NUM_BLOCKS` must be at least 2. Command codes: FFh read array, 40h or 10h program setup, 20h erase setup, D0h confirm or resume, B0h suspend, 70h read status, 50h clear status, 98h query, B8h configure.

Top module: `nfc_cmd_engine`

## Requirements
- R1: After 20h followed by D0h at an address inside block b, with the voltage flag high, the block erases. When it finishes, every byte of block b reads FFh and every byte of the other blocks keeps its value.
- R2: After 40h (or 10h) followed by a data write, with the voltage flag high, the byte becomes old AND data once PROG_CYCLES cycles have passed. Program only clears bits.
- R3: Starting an erase or a program switches the read mode to status. The mode stays there, across completion, until FFh is written.
- R4: Status word layout is bit 7 ready, bit 6 erase suspended, bit 5 erase failure, bit 4 program failure, bit 3 voltage failure, and bits 2..0 zero. B0h during a running erase sets bits 6 and 7 and raises the ready pin on the next cycle, and the erase makes no progress while suspended. B0h at any other time has no effect.
- R5: While an erase is suspended, only FFh, 40h/10h, 98h, 70h, 50h, B8h and D0h are acted on. Any other write, including 20h, changes neither status nor mode.
- R6: A program of another block issued during a suspend drives status bit 7 and the ready pin low while bit 6 stays 1.
- R7: D0h during a suspend clears status bits 6 and 7 and lowers the ready pin. The erase then finishes in fewer cycles than a full erase. A D0h written while a suspended-state program is running takes effect only after that program completes.
- R8: A program aimed at the block whose erase is suspended is rejected. It sets status bit 4 and leaves the byte unchanged.
- R9: 20h followed by any byte other than D0h sets status bits 5 and 4, selects status read mode and erases nothing.
- R10: With the voltage flag low, a program data write sets bits 4 and 3, and an erase confirm sets bits 5 and 3. Neither operation runs. A resume with the flag low ends the suspended erase, sets bits 5 and 3, clears bit 6 and leaves the block unerased.
- R11: 50h clears status bits 5, 4 and 3. 98h and B8h change neither status nor read mode.
- R12: After reset, the status word is 80h, the ready pin is high, the mode is array read and every byte is FFh. The read data output takes a new value only on the clock edge that samples the read strobe.
- R13: While an erase (not suspended) or a program is running, only 70h, B0h (erase only) and D0h (suspended-state program only) are acted on. All other writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for a command or data byte |
| addr | input | AW | Byte address used for writes and reads |
| wr_data | input | 8 | Command or data byte |
| rd_en | input | 1 | Read strobe; latches array byte or status into rd_data |
| vpp_ok | input | 1 | Program-enable voltage valid flag |
| rd_data | output | 8 | Latched read result |
| rdy_o | output | 1 | High when no operation is running or the erase is suspended |
| status_o | output | 8 | Current status word |

## Verification
On every cycle, the embedded assertions check several properties. A suspend during a running erase raises the ready bits on the next cycle. The erase counter stays frozen while suspended. A nested program lowers ready and keeps the suspend bit. A resume never reaches the erasing state before a nested program ends. A bad erase sequence sets both failure bits. A start of any operation comes with status read mode. A program only clears bits, and an erase fills its block. End-to-end effects can only be shown by the bench scenarios. These include the final contents of every block after erase, program and suspend interleavings, the rejection of the suspended block's program, the voltage-low abort on resume, and the shortened completion time after resume.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
    localparam logic [7:0] OP_PROG       = 8'h40;
    localparam logic [7:0] OP_PROG_ALT   = 8'h10;
    localparam logic [7:0] OP_ERASE      = 8'h20;
    localparam logic [7:0] OP_CONFIRM    = 8'hD0;
    localparam logic [7:0] OP_SUSPEND    = 8'hB0;
    localparam logic [7:0] OP_RD_STATUS  = 8'h70;
    localparam logic [7:0] OP_CLR_STATUS = 8'h50;
    localparam logic [7:0] OP_QUERY      = 8'h98;
    localparam logic [7:0] OP_CONFIG     = 8'hB8;

    typedef enum logic [1:0] {
        CMD_IDLE      = 2'd0,
        CMD_ERASE_ARM = 2'd1,
        CMD_PROG_ARM  = 2'd2
    } cmd_e;

    typedef enum logic {
        RM_ARRAY  = 1'b0,
        RM_STATUS = 1'b1
    } rmode_e;

    typedef enum logic [2:0] {
        WS_IDLE  = 3'd0,
        WS_ERASE = 3'd1,
        WS_ESUSP = 3'd2,
        WS_PROG  = 3'd3,
        WS_PSUSP = 3'd4
    } wsm_e;

endpackage

// File: rtl/nfc_op_timer.sv
module nfc_op_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] load,
    input  logic          run,
    output logic          done,
    output logic [CW-1:0] remain
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = load;
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done   = run && (cnt_q == CW'(1));
    assign remain = cnt_q;

    // R7: without a reload the count never grows, so progress is kept across suspend
    a_r7_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/nfc_array.sv
module nfc_array #(
    parameter int NUM_BLOCKS  = 4,
    parameter int BLOCK_BYTES = 16,
    localparam int DEPTH = NUM_BLOCKS * BLOCK_BYTES,
    localparam int AW    = $clog2(DEPTH),
    localparam int BW    = $clog2(NUM_BLOCKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase_en,
    input  logic [BW-1:0] erase_blk,
    input  logic          prog_en,
    input  logic [AW-1:0] prog_addr,
    input  logic [7:0]    prog_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (erase_en && (i / BLOCK_BYTES) == int'(erase_blk)) begin
                mem_d[i] = 8'hFF;
            end
        end
        if (prog_en) begin
            mem_d[prog_addr] = mem_q[prog_addr] & prog_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'hFF;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

    // R2: a programmed byte never has a bit set that the data byte had clear
    a_r2_bits_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> ((mem_q[$past(prog_addr)] & ~$past(prog_data)) == 8'h00));

    // R1: a finished erase leaves the first and last byte of the block at FFh
    a_r1_erase_fill: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (mem_q[int'($past(erase_blk)) * BLOCK_BYTES] == 8'hFF &&
                      mem_q[int'($past(erase_blk)) * BLOCK_BYTES + BLOCK_BYTES - 1] == 8'hFF));

endmodule

// File: rtl/nfc_cmd_engine.sv
module nfc_cmd_engine
    import nfc_pkg::*;
#(
    parameter int NUM_BLOCKS   = 4,
    parameter int BLOCK_BYTES  = 16,
    parameter int ERASE_CYCLES = 40,
    parameter int PROG_CYCLES  = 8,
    localparam int DEPTH = NUM_BLOCKS * BLOCK_BYTES,
    localparam int AW    = $clog2(DEPTH),
    localparam int BW    = $clog2(NUM_BLOCKS),
    localparam int MAXC  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES,
    localparam int CW    = $clog2(MAXC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    input  logic          vpp_ok,
    output logic [7:0]    rd_data,
    output logic          rdy_o,
    output logic [7:0]    status_o
);

    typedef struct packed {
        cmd_e          cmd;
        rmode_e        rmode;
        wsm_e          wsm;
        logic          sr_efail;
        logic          sr_pfail;
        logic          sr_vfail;
        logic [BW-1:0] eblk;
        logic [AW-1:0] paddr;
        logic [7:0]    pdata;
        logic          res_pend;
        logic [7:0]    rdat;
    } eng_t;

    eng_t n_d, n_q;

    logic          erase_go, prog_go;
    logic          erase_done, prog_done;
    logic [CW-1:0] erase_rem, prog_rem;
    logic [7:0]    arr_rd;
    logic          w_busy;
    logic [BW-1:0] addr_blk;
    logic          sr7, sr6;

    assign addr_blk = addr[AW-1 -: BW];
    assign sr7      = (n_q.wsm == WS_IDLE) || (n_q.wsm == WS_ESUSP);
    assign sr6      = (n_q.wsm == WS_ESUSP) || (n_q.wsm == WS_PSUSP);
    assign status_o = {sr7, sr6, n_q.sr_efail, n_q.sr_pfail, n_q.sr_vfail, 3'b000};
    assign rdy_o    = sr7;
    assign rd_data  = n_q.rdat;

    nfc_op_timer #(.CW(CW)) u_erase_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (erase_go),
        .load   (CW'(ERASE_CYCLES)),
        .run    (n_q.wsm == WS_ERASE),
        .done   (erase_done),
        .remain (erase_rem)
    );

    nfc_op_timer #(.CW(CW)) u_prog_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (prog_go),
        .load   (CW'(PROG_CYCLES)),
        .run    ((n_q.wsm == WS_PROG) || (n_q.wsm == WS_PSUSP)),
        .done   (prog_done),
        .remain (prog_rem)
    );

    nfc_array #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_en  (erase_done),
        .erase_blk (n_q.eblk),
        .prog_en   (prog_done),
        .prog_addr (n_q.paddr),
        .prog_data (n_q.pdata),
        .rd_addr   (addr),
        .rd_data   (arr_rd)
    );

    always_comb begin
        n_d      = n_q;
        erase_go = 1'b0;
        prog_go  = 1'b0;

        // completion of running operations
        case (n_q.wsm)
            WS_ERASE: if (erase_done) n_d.wsm = WS_IDLE;
            WS_PROG:  if (prog_done)  n_d.wsm = WS_IDLE;
            WS_PSUSP: if (prog_done) begin
                if (n_q.res_pend) begin
                    n_d.res_pend = 1'b0;
                    if (vpp_ok) begin
                        n_d.wsm = WS_ERASE;
                    end else begin
                        n_d.wsm      = WS_IDLE;
                        n_d.sr_efail = 1'b1;
                        n_d.sr_vfail = 1'b1;
                    end
                end else begin
                    n_d.wsm = WS_ESUSP;
                end
            end
            default: ;
        endcase

        w_busy = (n_d.wsm == WS_ERASE) || (n_d.wsm == WS_PROG) || (n_d.wsm == WS_PSUSP);

        if (wr_en) begin
            case (n_q.cmd)
                CMD_ERASE_ARM: begin
                    n_d.cmd   = CMD_IDLE;
                    n_d.rmode = RM_STATUS;
                    if (wr_data != OP_CONFIRM) begin
                        n_d.sr_efail = 1'b1;
                        n_d.sr_pfail = 1'b1;
                    end else if (!vpp_ok) begin
                        n_d.sr_efail = 1'b1;
                        n_d.sr_vfail = 1'b1;
                    end else begin
                        n_d.wsm  = WS_ERASE;
                        n_d.eblk = addr_blk;
                        erase_go = 1'b1;
                    end
                end
                CMD_PROG_ARM: begin
                    n_d.cmd   = CMD_IDLE;
                    n_d.rmode = RM_STATUS;
                    if (!vpp_ok) begin
                        n_d.sr_pfail = 1'b1;
                        n_d.sr_vfail = 1'b1;
                    end else if (n_d.wsm == WS_ESUSP && addr_blk == n_q.eblk) begin
                        n_d.sr_pfail = 1'b1;
                    end else begin
                        n_d.wsm   = (n_d.wsm == WS_ESUSP) ? WS_PSUSP : WS_PROG;
                        n_d.paddr = addr;
                        n_d.pdata = wr_data;
                        prog_go   = 1'b1;
                    end
                end
                default: begin
                    if (w_busy) begin
                        if (wr_data == OP_RD_STATUS) begin
                            n_d.rmode = RM_STATUS;
                        end else if (wr_data == OP_SUSPEND && n_d.wsm == WS_ERASE) begin
                            n_d.wsm = WS_ESUSP;
                        end else if (wr_data == OP_CONFIRM && n_d.wsm == WS_PSUSP) begin
                            n_d.res_pend = 1'b1;
                        end
                    end else begin
                        case (wr_data)
                            OP_READ_ARRAY: n_d.rmode = RM_ARRAY;
                            OP_RD_STATUS:  n_d.rmode = RM_STATUS;
                            OP_CLR_STATUS: begin
                                n_d.sr_efail = 1'b0;
                                n_d.sr_pfail = 1'b0;
                                n_d.sr_vfail = 1'b0;
                            end
                            OP_PROG, OP_PROG_ALT: n_d.cmd = CMD_PROG_ARM;
                            OP_ERASE: if (n_d.wsm == WS_IDLE) n_d.cmd = CMD_ERASE_ARM;
                            OP_CONFIRM: if (n_d.wsm == WS_ESUSP) begin
                                n_d.rmode = RM_STATUS;
                                if (vpp_ok) begin
                                    n_d.wsm = WS_ERASE;
                                end else begin
                                    n_d.wsm      = WS_IDLE;
                                    n_d.sr_efail = 1'b1;
                                    n_d.sr_vfail = 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            endcase
        end

        if (rd_en) begin
            n_d.rdat = (n_q.rmode == RM_ARRAY) ? arr_rd : status_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= '0;
        end else begin
            n_q <= n_d;
        end
    end

    // R4: suspend of a running erase shows ready and suspended on the next cycle
    a_r4_suspend_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && n_q.cmd == CMD_IDLE && wr_data == OP_SUSPEND &&
         n_q.wsm == WS_ERASE && !erase_done)
        |=> (rdy_o && status_o[7] && status_o[6]));

    // R4: no erase progress while suspended
    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ((n_q.wsm == WS_ESUSP || n_q.wsm == WS_PSUSP) &&
         ($past(n_q.wsm) == WS_ESUSP || $past(n_q.wsm) == WS_PSUSP))
        |-> $stable(erase_rem));

    // R6: program during suspend lowers ready and keeps the suspend bit
    a_r6_nested_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && n_q.cmd == CMD_PROG_ARM && n_q.wsm == WS_ESUSP && vpp_ok &&
         addr_blk != n_q.eblk)
        |=> (!rdy_o && !status_o[7] && status_o[6]));

    // R7: the erase cannot resume before the nested program completes
    a_r7_resume_held: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q.wsm == WS_PSUSP && !prog_done) |=> (n_q.wsm != WS_ERASE));

    // R9: a bad erase sequence sets both failure bits and selects status mode
    a_r9_bad_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && n_q.cmd == CMD_ERASE_ARM && wr_data != OP_CONFIRM)
        |=> (status_o[5] && status_o[4] && n_q.rmode == RM_STATUS));

    // R3: any operation start comes with status read mode
    a_r3_status_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_o) |-> (n_q.rmode == RM_STATUS));

    // R13: read-array writes are ignored while an erase runs
    a_r13_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && n_q.cmd == CMD_IDLE && n_q.wsm == WS_ERASE && !erase_done &&
         wr_data == OP_READ_ARRAY)
        |=> (n_q.rmode == $past(n_q.rmode)));

endmodule

// File: tb/nfc_cmd_engine_tb.sv
module nfc_cmd_engine_tb_top;

    localparam int NB    = 4;
    localparam int BB    = 16;
    localparam int EC    = 40;
    localparam int PC    = 8;
    localparam int DEPTH = NB * BB;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [AW-1:0] addr;
    logic [7:0]    wr_data;
    logic          rd_en;
    logic          vpp_ok;
    logic [7:0]    rd_data;
    logic          rdy_o;
    logic [7:0]    status_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    logic [7:0] model [DEPTH];

    always #2 clk = ~clk;

    nfc_cmd_engine #(
        .NUM_BLOCKS(NB), .BLOCK_BYTES(BB), .ERASE_CYCLES(EC), .PROG_CYCLES(PC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_en(rd_en), .vpp_ok(vpp_ok), .rd_data(rd_data), .rdy_o(rdy_o),
        .status_o(status_o)
    );

    function automatic logic [7:0] st(input bit r, input bit s, input bit ef,
                                      input bit pf, input bit vf);
        return {r, s, ef, pf, vf, 3'b000};
    endfunction

    function automatic logic [7:0] prog_result(input logic [7:0] old_v, input logic [7:0] new_v);
        return old_v & new_v;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic rd_arr(input int a, output logic [7:0] d);
        wr(0, 8'hFF);
        rd(a, d);
    endtask

    task automatic wait_ready(output int cyc);
        cyc = 0;
        while (!rdy_o && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic do_prog(input int a, input logic [7:0] d);
        int c;
        wr(a, 8'h40);
        wr(a, d);
        wait_ready(c);
        model[a] = prog_result(model[a], d);
    endtask

    task automatic do_erase(input int b);
        int c;
        wr(b * BB, 8'h20);
        wr(b * BB + 3, 8'hD0);
        wait_ready(c);
        for (int i = 0; i < BB; i++) model[b * BB + i] = 8'hFF;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int cyc;
        int seed_v;
        wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = 8'h00; vpp_ok = 1'b1;
        rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        seed_v = $urandom(32'h1F2E3D4C);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 reset status", status_o, st(1, 0, 0, 0, 0));
        chk("R12 reset ready", 8'(rdy_o), 8'h01);
        rd(5, d);
        chk("R12 reset array byte", d, 8'hFF);
        @(negedge clk);
        chk("R12 rd_data holds without strobe", rd_data, 8'hFF);

        // R2 / R3 / R13 program
        wr(5, 8'h40);
        wr(5, 8'hA5);
        chk("R2 ready low during program", 8'(rdy_o), 8'h00);
        rd(0, d);
        chk("R3 status mode after program start", d, st(0, 0, 0, 0, 0));
        wr(0, 8'hFF);
        wait_ready(cyc);
        rd(5, d);
        chk("R13 read-array ignored while busy, R3 mode kept", d, st(1, 0, 0, 0, 0));
        model[5] = prog_result(model[5], 8'hA5);
        rd_arr(5, d);
        chk("R2 program result", d, model[5]);
        do_prog(5, 8'h3C);
        rd_arr(5, d);
        chk("R2 program only clears bits", d, 8'h24);
        wr(9, 8'h10);
        wr(9, 8'h0F);
        wait_ready(cyc);
        model[9] = prog_result(model[9], 8'h0F);
        rd_arr(9, d);
        chk("R2 alternate program code", d, 8'h0F);

        // R1 erase with neighbours kept
        do_prog(20, 8'h12);
        do_prog(40, 8'h34);
        do_erase(1);
        rd_arr(20, d);
        chk("R1 erased byte", d, 8'hFF);
        rd(31, d);
        chk("R1 last byte of block erased", d, 8'hFF);
        rd(40, d);
        chk("R1 other block kept", d, 8'h34);
        rd(5, d);
        chk("R1 block 0 kept", d, 8'h24);

        // R9 bad sequence
        wr(16, 8'h20);
        wr(16, 8'h77);
        chk("R9 bad sequence status", status_o, st(1, 0, 1, 1, 0));
        rd(16, d);
        chk("R9 status mode after bad sequence", d, st(1, 0, 1, 1, 0));
        // R11 clear, query, configure
        wr(0, 8'h50);
        chk("R11 clear status", status_o, st(1, 0, 0, 0, 0));
        wr(0, 8'hFF);
        wr(0, 8'h98);
        wr(0, 8'hB8);
        rd(40, d);
        chk("R11 query and configure keep array mode", d, 8'h34);
        chk("R11 query and configure keep status", status_o, st(1, 0, 0, 0, 0));

        // R10 voltage low
        vpp_ok = 1'b0;
        wr(40, 8'h40);
        wr(40, 8'h00);
        chk("R10 program with voltage low", status_o, st(1, 0, 0, 1, 1));
        wr(0, 8'h50);
        wr(32, 8'h20);
        wr(32, 8'hD0);
        chk("R10 erase with voltage low", status_o, st(1, 0, 1, 0, 1));
        vpp_ok = 1'b1;
        rd_arr(40, d);
        chk("R10 byte untouched with voltage low", d, 8'h34);
        wr(0, 8'h50);

        // R4 suspend when idle ignored
        wr(0, 8'hB0);
        chk("R4 suspend when idle ignored", status_o, st(1, 0, 0, 0, 0));
        rd(40, d);
        chk("R4 idle suspend keeps array mode", d, 8'h34);

        // suspend scenario on block 2
        do_prog(33, 8'h11);
        do_prog(50, 8'h0F);
        wr(32, 8'h20);
        wr(33, 8'hD0);
        repeat (20) @(negedge clk);
        wr(0, 8'hB0);
        chk("R4 suspend sets bits 7 and 6", status_o, st(1, 1, 0, 0, 0));
        chk("R4 ready pin high on suspend", 8'(rdy_o), 8'h01);
        repeat (60) @(negedge clk);
        chk("R4 still suspended after long wait", status_o, st(1, 1, 0, 0, 0));
        rd_arr(33, d);
        chk("R5 array read while suspended, R4 block not erased", d, 8'h11);
        wr(0, 8'h70);
        wr(0, 8'h20);
        wr(0, 8'h77);
        chk("R5 erase setup ignored while suspended", status_o, st(1, 1, 0, 0, 0));
        // R8 program into suspended block
        wr(40, 8'h40);
        wr(40, 8'h00);
        chk("R8 program of suspended block rejected", status_o, st(1, 1, 0, 1, 0));
        rd_arr(40, d);
        chk("R8 suspended block byte unchanged", d, 8'h34);
        wr(0, 8'h50);
        chk("R11 clear during suspend", status_o, st(1, 1, 0, 0, 0));
        // R6 nested program, R7 held resume
        wr(7, 8'h40);
        wr(7, 8'h0F);
        chk("R6 nested program status", status_o, st(0, 1, 0, 0, 0));
        chk("R6 nested program ready low", 8'(rdy_o), 8'h00);
        wr(0, 8'hD0);
        chk("R7 resume held during nested program", status_o, st(0, 1, 0, 0, 0));
        cyc = 0;
        while (status_o[6] && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
        chk("R7 resume clears bits 7 and 6", status_o, st(0, 0, 0, 0, 0));
        chk("R7 ready low after resume", 8'(rdy_o), 8'h00);
        wait_ready(cyc);
        chk("R7 erase finished with remaining cycles", 8'(cyc < EC), 8'h01);
        chk("R7 status after resumed erase", status_o, st(1, 0, 0, 0, 0));
        model[7] = prog_result(model[7], 8'h0F);
        for (int i = 0; i < BB; i++) model[32 + i] = 8'hFF;
        rd_arr(33, d);
        chk("R1 suspended block erased after resume", d, 8'hFF);
        rd(40, d);
        chk("R1 suspended block fully erased", d, 8'hFF);
        rd(50, d);
        chk("R1 neighbour block kept across suspend", d, 8'h0F);
        rd(7, d);
        chk("R6 nested program landed", d, model[7]);

        // R10 resume with voltage low
        do_prog(17, 8'h5A);
        wr(16, 8'h20);
        wr(16, 8'hD0);
        repeat (10) @(negedge clk);
        wr(0, 8'hB0);
        vpp_ok = 1'b0;
        wr(0, 8'hD0);
        chk("R10 resume with voltage low aborts", status_o, st(1, 0, 1, 0, 1));
        vpp_ok = 1'b1;
        repeat (EC) @(negedge clk);
        rd_arr(17, d);
        chk("R10 aborted block not erased", d, 8'h5A);
        wr(0, 8'h50);

        // constrained random programs and erases
        for (int it = 0; it < 24; it++) begin
            int op;
            int a;
            logic [7:0] v;
            op = int'($urandom % 5);
            a  = int'($urandom % DEPTH);
            v  = 8'($urandom);
            if (op == 0) begin
                do_erase(a / BB);
            end else begin
                do_prog(a, v);
            end
            chk("R3 status after random op", status_o, st(1, 0, 0, 0, 0));
        end
        wr(0, 8'hFF);
        for (int i = 0; i < DEPTH; i++) begin
            rd(i, d);
            chk("R2 R1 random contents", d, model[i]);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule